// File: doc/BRIEF.md
# Serial Receive Data Register and Status Flags

This block sits between the receive shifter of a serial port and the processor bus. When the shifter reports a finished byte, the block moves the byte into its receive data register and raises a data-full flag. If a further byte finishes while that flag is still up, the new byte is thrown away, the old byte stays, and an overrun flag is raised. The overrun flag then stops all further reception, and in synchronous mode it stops transmission too.

Software clears a flag with a two-step handshake. It first reads the status register and sees the flag as 1. It then writes 0 to that flag's bit. A write that is not preceded by such a read has no effect. A DMA read of the data register also clears the data-full flag. A reception error, or a cleared receive-enable bit, leaves the data register and both flags as they were. The synchronous reset and the low-power clear input both force the flags to 0.

Top module: `rx_status_regs`

## Requirements
- R1: After `rst`, and one cycle after `lp_clr` is high, `full_o`, `ovr_o` and both handshake arms are 0. `rst` also sets `data_o` to 0. `lp_clr` leaves `data_o` unchanged.
- R2: A strobe on `rx_done` with `rx_en`=1, `rx_err`=0 and the overrun flag at 0, when data-full is 0 (or is being cleared in the same cycle), loads `rx_byte` into `data_o` and sets `full_o` on the next clock.
- R3: A status write with bit 1 (data-full) at 0 clears `full_o` only if an earlier status read returned bit 1 as 1. Bit 0 is the overrun flag.
- R4: Each flag has an arm bit. A status read returning the flag as 1 sets the arm. The next status write consumes the arm. A 0-write to a flag that is not armed leaves the flag unchanged.
- R5: Writing 1 to either status bit never sets a flag or changes it.
- R6: A byte completion with `rx_err`=1 or `rx_en`=0 leaves `data_o`, `full_o` and `ovr_o` unchanged.
- R7: An accepted completion while data-full stays 1 sets `ovr_o`, keeps the old `data_o`, and drops the new byte.
- R8: While `ovr_o`=1, completions are ignored and `rx_allow_o`=0. `tx_allow_o` is 0 only when `ovr_o`=1 and `sync_mode`=1.
- R9: A `dma_rd` pulse clears `full_o` without any handshake.
- R10: The overrun flag clears only through the R3/R4 handshake on bit 0, or through `rst`/`lp_clr`. A `rx_en` of 0 does not clear it.
- R11: A completion in the same cycle as a software clear of data-full is accepted. `full_o` stays 1, `data_o` takes the new byte, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_clr | input | 1 | Low-power/standby clear of the flags |
| rx_done | input | 1 | Shifter finished a byte (one-cycle strobe) |
| rx_byte | input | DATA_W | Byte from the shift register |
| rx_err | input | 1 | Error detected on this reception |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Write data: bit 1 data-full, bit 0 overrun |
| dma_rd | input | 1 | DMA read of the data register |
| stat_rdata | output | 2 | Status: bit 1 data-full, bit 0 overrun |
| data_o | output | DATA_W | Receive data register |
| full_o | output | 1 | Data-full flag |
| ovr_o | output | 1 | Overrun flag |
| rx_allow_o | output | 1 | Reception permitted |
| tx_allow_o | output | 1 | Transmission permitted |

## Verification
A stuck or wrongly set arm bit shows up at the first 0-write after a status read: `full_o` or `ovr_o` fails to drop, or drops too early, on the very next clock. A wrong acceptance decision shows on the clock after the `rx_done` strobe. In that case `data_o` changes when it should hold, or `ovr_o` rises with the old byte replaced. If the overrun state is lost, a later byte is wrongly accepted and `rx_allow_o` stays high.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int STAT_W   = 2;
  localparam int FULL_BIT = 1;
  localparam int OVR_BIT  = 0;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/rx_flag_cell.sv
// One status flag with its read-one/write-zero arm bit.
module rx_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic lp_clr,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic hw_clr_i,
  output logic flag_o,
  output logic sw_clr_o
);
  logic flag_q;
  logic arm_q;

  assign sw_clr_o = wr_i & ~wbit_i & arm_q;
  assign flag_o   = flag_q;

  always_ff @(posedge clk) begin
    if (rst || lp_clr) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)
        flag_q <= 1'b1;
      else if (sw_clr_o || hw_clr_i)
        flag_q <= 1'b0;
      // a write consumes the arm; a read seeing 1 re-arms
      arm_q <= (wr_i ? 1'b0 : arm_q) | (rd_i & flag_q);
    end
  end
endmodule

// File: rtl/rx_accept.sv
// Decides what a finished byte does: load, overrun, or nothing.
module rx_accept (
  input  logic rx_done,
  input  logic rx_err,
  input  logic rx_en,
  input  logic ovr_q,
  input  logic full_q,
  input  logic full_clr,
  output logic load_o,
  output logic overrun_o
);
  logic good;
  logic full_eff;

  always_comb begin
    good      = rx_done & rx_en & ~rx_err & ~ovr_q;
    full_eff  = full_q & ~full_clr;
    load_o    = good & ~full_eff;
    overrun_o = good & full_eff;
  end
endmodule

// File: rtl/rx_data_reg.sv
module rx_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (load_i)
      dout <= din;
  end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_clr,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_err,
  input  logic              rx_en,
  input  logic              sync_mode,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [1:0]        stat_wdata,
  input  logic              dma_rd,
  output logic [1:0]        stat_rdata,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rx_allow_o,
  output logic              tx_allow_o
);
  logic full_q, ovr_q;
  logic full_swclr, ovr_swclr;
  logic load, overrun;

  rx_accept u_accept (
    .rx_done  (rx_done),
    .rx_err   (rx_err),
    .rx_en    (rx_en),
    .ovr_q    (ovr_q),
    .full_q   (full_q),
    .full_clr (full_swclr | dma_rd),
    .load_o   (load),
    .overrun_o(overrun)
  );

  rx_flag_cell u_full (
    .clk     (clk),
    .rst     (rst),
    .lp_clr  (lp_clr),
    .rd_i    (stat_rd),
    .wr_i    (stat_wr),
    .wbit_i  (stat_wdata[FULL_BIT]),
    .set_i   (load),
    .hw_clr_i(dma_rd),
    .flag_o  (full_q),
    .sw_clr_o(full_swclr)
  );

  rx_flag_cell u_ovr (
    .clk     (clk),
    .rst     (rst),
    .lp_clr  (lp_clr),
    .rd_i    (stat_rd),
    .wr_i    (stat_wr),
    .wbit_i  (stat_wdata[OVR_BIT]),
    .set_i   (overrun),
    .hw_clr_i(1'b0),
    .flag_o  (ovr_q),
    .sw_clr_o(ovr_swclr)
  );

  rx_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .din   (rx_byte),
    .dout  (data_o)
  );

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[FULL_BIT] = full_q;
    stat_rdata[OVR_BIT]  = ovr_q;
  end

  assign full_o     = full_q;
  assign ovr_o      = ovr_q;
  assign rx_allow_o = ~ovr_q;
  assign tx_allow_o = ~(ovr_q & sync_mode);
endmodule

// File: rtl/rx_status_regs_chk.sv
module rx_status_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lp_clr,
  input logic              rx_done,
  input logic              rx_err,
  input logic              rx_en,
  input logic              stat_wr,
  input logic [1:0]        stat_wdata,
  input logic              dma_rd,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              rx_allow_o
);
  assert_lp_clears_R1: assert property (@(posedge clk) disable iff (rst)
    lp_clr |=> (!full_o && !ovr_o));

  assert_full_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(full_o) |-> ($past(rx_done) && $past(rx_en) && !$past(rx_err) && !$past(lp_clr)));

  assert_one_write_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (full_o && stat_wr && stat_wdata[1] && !dma_rd && !lp_clr) |=> full_o);

  assert_bad_rx_no_load_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_done && rx_en && !rx_err) |=> $stable(data_o));

  assert_ovr_keeps_old_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> (data_o == $past(data_o)));

  assert_ovr_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    ovr_o |=> $stable(data_o));

  assert_allow_low_R8: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> !rx_allow_o);

  assert_ovr_held_R10: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !stat_wr && !lp_clr) |=> ovr_o);
endmodule

bind rx_status_regs rx_status_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lp_clr    (lp_clr),
  .rx_done   (rx_done),
  .rx_err    (rx_err),
  .rx_en     (rx_en),
  .stat_wr   (stat_wr),
  .stat_wdata(stat_wdata),
  .dma_rd    (dma_rd),
  .data_o    (data_o),
  .full_o    (full_o),
  .ovr_o     (ovr_o),
  .rx_allow_o(rx_allow_o)
);

// File: tb/rx_status_regs_test.sv
module rx_status_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst, lp_clr, rx_done, rx_err, rx_en, sync_mode;
  logic stat_rd, stat_wr, dma_rd;
  logic [1:0] stat_wdata, stat_rdata;
  logic [DATA_W-1:0] rx_byte, data_o;
  logic full_o, ovr_o, rx_allow_o, tx_allow_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_regs #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .lp_clr(lp_clr), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_err(rx_err), .rx_en(rx_en), .sync_mode(sync_mode), .stat_rd(stat_rd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .dma_rd(dma_rd),
    .stat_rdata(stat_rdata), .data_o(data_o), .full_o(full_o), .ovr_o(ovr_o),
    .rx_allow_o(rx_allow_o), .tx_allow_o(tx_allow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs are driven after a falling edge; results are sampled at the next falling edge
  task automatic idle();
    rx_done = 0; rx_err = 0; stat_rd = 0; stat_wr = 0; dma_rd = 0; lp_clr = 0;
    stat_wdata = 2'b11;
  endtask

  task automatic rx(input logic [7:0] b, input logic err, input logic en);
    @(negedge clk); rx_done = 1; rx_byte = b; rx_err = err; rx_en = en;
    @(negedge clk); idle(); rx_en = 1;
  endtask

  task automatic sread();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); idle();
  endtask

  task automatic swrite(input logic [1:0] w);
    @(negedge clk); stat_wr = 1; stat_wdata = w;
    @(negedge clk); idle();
  endtask

  task automatic dma();
    @(negedge clk); dma_rd = 1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 full after rst", full_o, 0);
    chk("R1 ovr after rst", ovr_o, 0);
    chk("R1 data after rst", data_o, 0);
    chk("R8 rx_allow after rst", rx_allow_o, 1);
  endtask

  task automatic t_load_and_clear();
    rx(8'hA5, 0, 1);
    chk("R2 full set", full_o, 1);
    chk("R2 data", data_o, 8'hA5);
    chk("R2 status bit1", stat_rdata, 2'b10);
    swrite(2'b00);
    chk("R4 unarmed zero-write", full_o, 1);
    sread();
    swrite(2'b11);
    chk("R5 one-write keeps full", full_o, 1);
    swrite(2'b00);
    chk("R4 arm consumed by write", full_o, 1);
    sread();
    swrite(2'b01);
    chk("R3 handshake clears full", full_o, 0);
    chk("R3 ovr untouched", ovr_o, 0);
  endtask

  task automatic t_ignored();
    rx(8'h5A, 1, 1);
    chk("R6 err full", full_o, 0);
    chk("R6 err data", data_o, 8'hA5);
    rx(8'h66, 0, 0);
    chk("R6 disabled full", full_o, 0);
    chk("R6 disabled data", data_o, 8'hA5);
  endtask

  task automatic t_overrun();
    rx(8'h3C, 0, 1);
    rx(8'h77, 0, 1);
    chk("R7 ovr set", ovr_o, 1);
    chk("R7 old data kept", data_o, 8'h3C);
    chk("R7 full stays", full_o, 1);
    chk("R8 rx_allow low", rx_allow_o, 0);
    @(negedge clk); sync_mode = 0; #1;
    chk("R8 async tx allowed", tx_allow_o, 1);
    sync_mode = 1; #1;
    chk("R8 sync tx blocked", tx_allow_o, 0);
    sync_mode = 0;
    dma();
    chk("R9 dma clears full", full_o, 0);
    rx(8'h11, 0, 1);
    chk("R8 blocked rx full", full_o, 0);
    chk("R8 blocked rx data", data_o, 8'h3C);
    rx(8'h22, 0, 0);
    chk("R10 rx_en low keeps ovr", ovr_o, 1);
    swrite(2'b10);
    chk("R10 unarmed write keeps ovr", ovr_o, 1);
    sread();
    swrite(2'b10);
    chk("R10 handshake clears ovr", ovr_o, 0);
    chk("R8 rx_allow back", rx_allow_o, 1);
    rx(8'h44, 0, 1);
    chk("R2 rx resumes", data_o, 8'h44);
  endtask

  task automatic t_same_cycle();
    sread();
    @(negedge clk); stat_wr = 1; stat_wdata = 2'b01; rx_done = 1; rx_byte = 8'hC3; rx_en = 1;
    @(negedge clk); idle();
    chk("R11 full", full_o, 1);
    chk("R11 data", data_o, 8'hC3);
    chk("R11 no ovr", ovr_o, 0);
  endtask

  task automatic t_lowpower();
    rx(8'h99, 0, 1);
    chk("R7 second ovr", ovr_o, 1);
    @(negedge clk); lp_clr = 1;
    @(negedge clk); idle();
    chk("R1 lp full", full_o, 0);
    chk("R1 lp ovr", ovr_o, 0);
    chk("R1 lp data kept", data_o, 8'hC3);
    swrite(2'b00);
    rx(8'h10, 0, 1);
    chk("R1 lp arms cleared", full_o, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    t_reset();
  endtask

  initial begin
    rst = 1; rx_byte = '0; rx_en = 1; sync_mode = 0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load_and_clear();
    t_ignored();
    t_overrun();
    t_same_cycle();
    t_lowpower();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule